// File: doc/BRIEF.md
# Pseudo-Random Test Stream Source and Checker

This block supplies the built-in self-test traffic for a serial coded link. On the sending side a nine-stage shift register with XNOR feedback produces a maximal-length pseudo-random bit stream whenever test mode is on. On the receiving side a second copy of the same register first captures nine received bits to pick up the sequence phase. It then runs on its own and predicts every following bit, so the checker needs no shared start point with the sender.

Each received test bit is compared against the local prediction, and the result appears one cycle later as a pass/fail pulse. A sticky flag records that any mismatch occurred since the last clear. Both serial sides use a valid/ready handshake. The sender offers a bit (`tx_valid`) whenever test mode is on and advances only when the sink raises `tx_ready`. The receiver takes bits only while test mode is on (`rx_ready` follows `test_en`) and never applies any other back-pressure.

Top module: `prbs9_bist`

## Requirements
- R1: Driving `clr_n` low clears every register stage, `tx_bit`, `bit_err`, `err_sticky` and `rx_locked` to 0 at once, without waiting for a clock edge.
- R2: On a clock edge where `test_en` and `tx_ready` are both 1, `tx_taps[k]` takes the old `tx_taps[k-1]` for k = 1..8, and `tx_taps[0]` takes the XNOR of the old `tx_taps[4]` and `tx_taps[8]` (bit k-1 of `tx_taps` is stage k).
- R3: On any edge where `test_en` or `tx_ready` is 0, the sending register keeps its value; `tx_valid` equals `test_en`.
- R4: `tx_bit` is stage 9 (`tx_taps[8]`). Starting from the cleared state, the register first returns to all zeros after exactly 511 advances and never holds all ones.
- R5: `rx_ready` equals `test_en`. A received bit is taken only on an edge where `rx_valid` and `rx_ready` are both 1; all other bits leave the checker untouched.
- R6: After a clear, the first nine taken bits are loaded into the receive register. `rx_locked` is 1 from the cycle after the ninth taken bit until the next clear.
- R7: After lock, every taken bit is compared with the prediction, which is the XNOR of receive stages 5 and 9. In the following cycle `bit_err` is 1 if they differ and 0 if they match. `bit_err` is 0 in the cycle after any edge with no taken bit, and in the cycle after any edge taken while unlocked.
- R8: After lock, the receive register advances on its own prediction rather than on the received bit, so one corrupted bit gives exactly one `bit_err` pulse.
- R9: `err_sticky` becomes 1 in the same cycle as any `bit_err` pulse and stays 1 until a clear.
- R10: The checker locks correctly at any phase of the sequence, and an error-free stream then never raises `bit_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| test_en | input | 1 | Test mode: enables the sender and the receive handshake |
| tx_ready | input | 1 | Sink accepts the offered test bit |
| tx_valid | output | 1 | A test bit is offered |
| tx_bit | output | 1 | Serial test bit (stage 9) |
| tx_taps | output | 9 | All sending stages, bit k-1 = stage k |
| rx_valid | input | 1 | Received bit present |
| rx_bit | input | 1 | Received serial bit |
| rx_ready | output | 1 | Checker accepts received bits |
| rx_locked | output | 1 | Receive register loaded, comparison active |
| bit_err | output | 1 | Per-bit mismatch result, one cycle after the bit |
| err_sticky | output | 1 | Mismatch seen since last clear |

## Verification
The hardest case to reach is a mismatch on a locked checker that starts at an arbitrary phase, interleaved with bits that must be ignored. The stimulus computes the reference sequence arithmetically, skips ahead by several offsets, and feeds the checker while dropping `test_en` or `rx_valid` on a fixed pattern. It flips single bits on the very first tracked bit and deep into the stream, then counts the resulting pulses. The full 511-state period is swept under an irregular `tx_ready`/`test_en` stall pattern.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int unsigned PRBS_LEN = 9;
  localparam int unsigned PRBS_MID = 5;
  typedef enum logic {RX_FILL = 1'b0, RX_TRACK = 1'b1} rx_mode_e;
endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int unsigned LEN = prbs_pkg::PRBS_LEN,
  parameter int unsigned MID = prbs_pkg::PRBS_MID
) (
  input  logic           clk,
  input  logic           clr_n,
  input  logic           adv,
  input  logic           load_en,
  input  logic           load_bit,
  output logic [LEN-1:0] state,
  output logic           fb
);
  logic           in_bit;
  logic [LEN-1:0] nxt;

  // XNOR feedback keeps the all-zero state inside the sequence
  assign fb     = ~(state[MID-1] ^ state[LEN-1]);
  assign in_bit = load_en ? load_bit : fb;

  for (genvar k = 0; k < LEN; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign nxt[k] = in_bit;
    end else begin : g_body
      assign nxt[k] = state[k-1];
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   state <= '0;
    else if (adv) state <= nxt;
  end

  a_r2_shift_chain: assert property (@(posedge clk) disable iff (!clr_n)
    adv |=> state[LEN-1:1] == $past(state[LEN-2:0]));
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!clr_n)
    !adv |=> $stable(state));
endmodule

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen #(
  parameter int unsigned LEN = prbs_pkg::PRBS_LEN,
  parameter int unsigned MID = prbs_pkg::PRBS_MID
) (
  input  logic           clk,
  input  logic           clr_n,
  input  logic           test_en,
  input  logic           tx_ready,
  output logic           tx_valid,
  output logic           tx_bit,
  output logic [LEN-1:0] taps
);
  logic adv;
  logic fb_unused;

  assign tx_valid = test_en;
  assign adv      = test_en & tx_ready;

  prbs_lfsr #(.LEN(LEN), .MID(MID)) u_reg (
    .clk(clk), .clr_n(clr_n), .adv(adv), .load_en(1'b0), .load_bit(1'b0),
    .state(taps), .fb(fb_unused)
  );

  assign tx_bit = taps[LEN-1];

  a_r4_no_lockup: assert property (@(posedge clk) disable iff (!clr_n)
    taps != '1);
  a_r3_stall_stable: assert property (@(posedge clk) disable iff (!clr_n)
    (tx_valid && !tx_ready) |=> $stable(tx_bit));
endmodule

// File: rtl/prbs_rx_chk.sv
module prbs_rx_chk #(
  parameter int unsigned LEN = prbs_pkg::PRBS_LEN,
  parameter int unsigned MID = prbs_pkg::PRBS_MID
) (
  input  logic clk,
  input  logic clr_n,
  input  logic test_en,
  input  logic rx_valid,
  input  logic rx_bit,
  output logic rx_ready,
  output logic rx_locked,
  output logic bit_err,
  output logic err_sticky
);
  import prbs_pkg::*;
  localparam int unsigned CW = $clog2(LEN + 1);

  rx_mode_e       mode;
  logic [CW-1:0]  fill_cnt;
  logic [LEN-1:0] ref_state;
  logic           predict;
  logic           take;
  logic           miss;

  assign rx_ready  = test_en;
  assign take      = rx_valid & test_en;
  assign rx_locked = (mode == RX_TRACK);
  assign miss      = take & rx_locked & (rx_bit != predict);

  prbs_lfsr #(.LEN(LEN), .MID(MID)) u_ref (
    .clk(clk), .clr_n(clr_n), .adv(take), .load_en(mode == RX_FILL),
    .load_bit(rx_bit), .state(ref_state), .fb(predict)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      mode     <= RX_FILL;
      fill_cnt <= '0;
    end else if (take && mode == RX_FILL) begin
      fill_cnt <= fill_cnt + 1'b1;
      if (fill_cnt == CW'(LEN - 1)) mode <= RX_TRACK;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      bit_err    <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      bit_err    <= miss;
      err_sticky <= err_sticky | miss;
    end
  end

  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!clr_n)
    rx_locked |=> rx_locked);
  a_r7_quiet_unlocked: assert property (@(posedge clk) disable iff (!clr_n)
    !rx_locked |=> !bit_err);
  a_r7_quiet_no_take: assert property (@(posedge clk) disable iff (!clr_n)
    !(rx_valid && rx_ready) |=> !bit_err);
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!clr_n)
    err_sticky |=> err_sticky);
  a_r9_err_marks: assert property (@(posedge clk) disable iff (!clr_n)
    bit_err |-> err_sticky);
endmodule

// File: rtl/prbs9_bist.sv
module prbs9_bist #(
  parameter int unsigned LEN = prbs_pkg::PRBS_LEN,
  parameter int unsigned MID = prbs_pkg::PRBS_MID
) (
  input  logic           clk,
  input  logic           clr_n,
  input  logic           test_en,
  input  logic           tx_ready,
  output logic           tx_valid,
  output logic           tx_bit,
  output logic [LEN-1:0] tx_taps,
  input  logic           rx_valid,
  input  logic           rx_bit,
  output logic           rx_ready,
  output logic           rx_locked,
  output logic           bit_err,
  output logic           err_sticky
);
  prbs_tx_gen #(.LEN(LEN), .MID(MID)) u_tx (
    .clk(clk), .clr_n(clr_n), .test_en(test_en), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .taps(tx_taps)
  );

  prbs_rx_chk #(.LEN(LEN), .MID(MID)) u_rx (
    .clk(clk), .clr_n(clr_n), .test_en(test_en), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .rx_ready(rx_ready), .rx_locked(rx_locked),
    .bit_err(bit_err), .err_sticky(err_sticky)
  );

  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> (tx_taps == '0 && !rx_locked && !err_sticky));
endmodule

// File: tb/tb_prbs9_bist.sv
module tb_prbs9_bist;
  logic clk = 1'b0, clr_n = 1'b0, test_en = 1'b0, tx_ready = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0;
  logic tx_valid, tx_bit, rx_ready, rx_locked, bit_err, err_sticky;
  logic [8:0] tx_taps;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prbs9_bist dut (
    .clk(clk), .clr_n(clr_n), .test_en(test_en), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_taps(tx_taps),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_ready(rx_ready),
    .rx_locked(rx_locked), .bit_err(bit_err), .err_sticky(err_sticky)
  );

  function automatic logic [8:0] nxt(input logic [8:0] s);
    return {s[7:0], ~(s[4] ^ s[8])};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_clear;
    clr_n = 1'b0;
    step();
    clr_n = 1'b1;
  endtask

  // R5 R6 R7 R8 R10: feed a reference stream from a chosen phase
  task automatic rx_run(input int phase, input int nbits, input int err_at, input bit gaps);
    logic [8:0] s;
    int acc, pulses;
    s = '0;
    acc = 0;
    pulses = 0;
    tx_ready = 1'b0;
    for (int p = 0; p < phase; p++) s = nxt(s);
    for (int j = 0; acc < nbits; j++) begin
      bit gap, idle, taken, exp_err;
      gap  = gaps && (j % 11 == 4);
      idle = gaps && (j % 13 == 7);
      test_en  = !gap;
      rx_valid = !idle;
      if (gap || idle) rx_bit = ~s[8];
      else rx_bit = (acc == err_at) ? ~s[8] : s[8];
      taken   = test_en && rx_valid;
      exp_err = taken && (acc == err_at) && (acc >= 9);
      step();
      if (taken) begin
        acc++;
        s = nxt(s);
      end
      if (bit_err) pulses++;
      chk(bit_err == exp_err, taken ? "R7 compare" : "R5 ignored bit", bit_err, exp_err);
      chk(rx_locked == (acc >= 9), "R6 lock", rx_locked, acc >= 9);
    end
    chk(pulses == (err_at >= 0 ? 1 : 0), "R8 single pulse", pulses, err_at >= 0 ? 1 : 0);
    chk(err_sticky == (err_at >= 0), "R9 sticky", err_sticky, err_at >= 0);
  endtask

  initial begin
    logic [8:0] m;
    int adv_cnt, first_ret;
    bit saw_ones;
    m = '0;
    adv_cnt = 0;
    first_ret = -1;
    saw_ones = 1'b0;
    @(negedge clk);
    step();
    step();
    // R1 reset state
    chk(tx_taps == 9'd0, "R1 taps", tx_taps, 0);
    chk(!tx_bit && !bit_err && !err_sticky && !rx_locked, "R1 flags",
        {tx_bit, bit_err, err_sticky, rx_locked}, 0);
    clr_n = 1'b1;

    // R2 R3 R4: period sweep under stalls
    for (int i = 0; i < 1200; i++) begin
      test_en  = (i % 7) != 6;
      tx_ready = (i % 5) != 3;
      #1;
      chk(tx_valid == test_en, "R3 valid", tx_valid, test_en);
      chk(rx_ready == test_en, "R5 ready", rx_ready, test_en);
      step();
      if (test_en && tx_ready) begin
        m = nxt(m);
        adv_cnt++;
      end
      chk(tx_taps == m, (test_en && tx_ready) ? "R2 advance" : "R3 hold", tx_taps, m);
      chk(tx_bit == m[8], "R4 serial", tx_bit, m[8]);
      chk(!bit_err && !rx_locked, "R7 idle rx", bit_err, 0);
      if (tx_taps == 9'h1ff) saw_ones = 1'b1;
      if (first_ret < 0 && adv_cnt > 0 && tx_taps == 9'd0) first_ret = adv_cnt;
    end
    chk(first_ret == 511, "R4 period", first_ret, 511);
    chk(!saw_ones, "R4 lockup", saw_ones, 0);

    // R1 asynchronous clear mid-run
    test_en = 1'b1;
    tx_ready = 1'b1;
    step();
    step();
    step();
    #2 clr_n = 1'b0;
    #1 chk(tx_taps == 9'd0, "R1 async", tx_taps, 0);
    @(negedge clk);
    clr_n = 1'b1;

    rx_run(137, 200, 40, 1'b1);
    rx_valid = 1'b0;
    step();
    step();
    chk(err_sticky == 1'b1, "R9 held", err_sticky, 1);
    chk(bit_err == 1'b0, "R7 no take", bit_err, 0);
    clr_n = 1'b0;
    #1 chk(!err_sticky && !rx_locked, "R1 rx clear", {err_sticky, rx_locked}, 0);
    @(negedge clk);
    clr_n = 1'b1;
    rx_run(400, 600, -1, 1'b0);  // R10 clean stream at another phase
    do_clear();
    rx_run(0, 30, 9, 1'b1);      // R8 first tracked bit corrupted
    do_clear();
    rx_run(509, 40, 25, 1'b0);   // R10 phase near wrap

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule